// File: doc/BRIEF.md
# Banked Edge Interrupt Unit

This block watches the 32 pins of one bank for transitions and converts them into interrupt requests. Each pin has two independent edge enables, one for a low-to-high change and one for a high-to-low change. Software sets and clears these enables through separate write-one registers, so it can change one pin without a read-modify-write sequence. When an enabled transition occurs, the pin's bit in a sticky status register is set. Software clears that bit by writing a one to it.

The bank drives two level-sensitive interrupt lines. The lower line covers pins 0 to 15 and the upper line covers pins 16 to 31. Each line is gated by its own bit in a group enable register. The pin inputs are assumed to be synchronized to the block clock already. Register reads are combinational from the address.

Top module: `irq_edge_bank`

## Requirements
- R1: After reset, both edge masks, the status register and the group enable bits are zero, and both interrupt lines are low.
- R2: A write to offset 0x14 sets the rise-enable bit of each pin whose data bit is 1. Data bits of 0 leave the mask unchanged. A read of 0x14 or 0x18 returns the rise mask.
- R3: A write to offset 0x18 clears the rise-enable bit of each pin whose data bit is 1. A pin whose rise enable is cleared no longer records low-to-high changes.
- R4: Writes to 0x1C and 0x20 set and clear the fall-enable bits in the same way. A read of 0x1C or 0x20 returns the fall mask.
- R5: A pin whose sampled value is 1 while its value one clock earlier was 0 sets its status bit on that same clock edge, provided its rise enable is set. Without the enable, the status bit stays unchanged.
- R6: A pin whose sampled value is 0 while its value one clock earlier was 1 sets its status bit when its fall enable is set.
- R7: With both enables set, a pin records both kinds of transition.
- R8: The status register reads at 0x24. Writing a 1 to a bit clears that bit, and bits written as 0 are unaffected.
- R9: If a transition event and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R10: The group enable register sits at 0x08. Bit 0 gates the line for pins 0–15 and bit 1 gates the line for pins 16–31. Its other bits read as zero.
- R11: Line g (irq_grp[g]) is high exactly while its enable bit is set and at least one status bit in its 16-pin half is set.
- R12: A read of any unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 32 | Synchronized pin levels |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_grp | output | 2 | Level interrupt lines; bit 0 is pins 0–15, bit 1 is pins 16–31 |

## Verification
Two things can land on the same status bit in one clock cycle: a newly detected transition, and a write-one-to-clear from software. The bench provokes this by changing a pin's level in the same cycle that it writes a 1 to that pin's status bit. It then reads the status register back and expects the bit to still be set. It also clears a different bit in a cycle with no event, which shows that the clear path on its own does work.

// File: rtl/irq_edge_pkg.sv
package irq_edge_pkg;
    localparam int PIN_W  = 32;
    localparam int GRP_W  = 16;
    localparam int ADDR_W = 8;
    localparam int NUM_GRP = PIN_W / GRP_W;

    // Offsets: edge and status registers keep their fixed bank positions
    localparam logic [ADDR_W-1:0] OFS_GRP_EN   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_RISE_SET = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_RISE_CLR = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_FALL_SET = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_FALL_CLR = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_STATUS   = 8'h24;

    typedef struct packed {
        logic rise_set;
        logic rise_clr;
        logic fall_set;
        logic fall_clr;
        logic stat_clr;
        logic grp_wr;
    } wr_strobe_t;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    output logic [W-1:0] evt
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin;
    end

    always_comb begin
        evt = (pin & ~prev_q & rise_en) | (~pin & prev_q & fall_en);
    end
endmodule

// File: rtl/irq_edge_mask.sv
module irq_edge_mask #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask
);
    logic [W-1:0] set_bits;
    logic [W-1:0] clr_bits;

    always_comb begin
        set_bits = set_stb ? wdata : '0;
        clr_bits = clr_stb ? wdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask <= '0;
        else        mask <= (mask | set_bits) & ~clr_bits;
    end
endmodule

// File: rtl/irq_edge_status.sv
module irq_edge_status #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr_stb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] stat
);
    logic [W-1:0] clr_bits;

    always_comb clr_bits = clr_stb ? wdata : '0;

    // a fresh event overrides a simultaneous clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat & ~clr_bits) | evt;
    end
endmodule

// File: rtl/irq_edge_group.sv
module irq_edge_group #(
    parameter int PIN_W = 32,
    parameter int GRP_W = 16,
    localparam int NUM_GRP = PIN_W / GRP_W
) (
    input  logic [PIN_W-1:0]   stat,
    input  logic [NUM_GRP-1:0] grp_en,
    output logic [NUM_GRP-1:0] irq
);
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        assign irq[g] = grp_en[g] & (|stat[g*GRP_W +: GRP_W]);
    end
endmodule

// File: rtl/irq_edge_bank.sv
module irq_edge_bank
    import irq_edge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIN_W-1:0]  pin_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PIN_W-1:0]  bus_wdata,
    output logic [PIN_W-1:0]  bus_rdata,
    output logic [NUM_GRP-1:0] irq_grp
);
    wr_strobe_t         stb;
    logic [PIN_W-1:0]   rise_mask;
    logic [PIN_W-1:0]   fall_mask;
    logic [PIN_W-1:0]   evt_vec;
    logic [PIN_W-1:0]   stat_vec;
    logic [NUM_GRP-1:0] grp_en_q;

    always_comb begin
        stb = '0;
        if (bus_wr) begin
            case (bus_addr)
                OFS_RISE_SET: stb.rise_set = 1'b1;
                OFS_RISE_CLR: stb.rise_clr = 1'b1;
                OFS_FALL_SET: stb.fall_set = 1'b1;
                OFS_FALL_CLR: stb.fall_clr = 1'b1;
                OFS_STATUS:   stb.stat_clr = 1'b1;
                OFS_GRP_EN:   stb.grp_wr   = 1'b1;
                default: ;
            endcase
        end
    end

    irq_edge_mask #(.W(PIN_W)) rise_i (
        .clk(clk), .rst_n(rst_n), .set_stb(stb.rise_set), .clr_stb(stb.rise_clr),
        .wdata(bus_wdata), .mask(rise_mask)
    );

    irq_edge_mask #(.W(PIN_W)) fall_i (
        .clk(clk), .rst_n(rst_n), .set_stb(stb.fall_set), .clr_stb(stb.fall_clr),
        .wdata(bus_wdata), .mask(fall_mask)
    );

    irq_edge_detect #(.W(PIN_W)) det_i (
        .clk(clk), .rst_n(rst_n), .pin(pin_in), .rise_en(rise_mask),
        .fall_en(fall_mask), .evt(evt_vec)
    );

    irq_edge_status #(.W(PIN_W)) stat_i (
        .clk(clk), .rst_n(rst_n), .evt(evt_vec), .clr_stb(stb.stat_clr),
        .wdata(bus_wdata), .stat(stat_vec)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          grp_en_q <= '0;
        else if (stb.grp_wr) grp_en_q <= bus_wdata[NUM_GRP-1:0];
    end

    irq_edge_group #(.PIN_W(PIN_W), .GRP_W(GRP_W)) grp_i (
        .stat(stat_vec), .grp_en(grp_en_q), .irq(irq_grp)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_RISE_SET, OFS_RISE_CLR: bus_rdata = rise_mask;
            OFS_FALL_SET, OFS_FALL_CLR: bus_rdata = fall_mask;
            OFS_STATUS:                 bus_rdata = stat_vec;
            OFS_GRP_EN:                 bus_rdata[NUM_GRP-1:0] = grp_en_q;
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_edge_bank_chk.sv
module irq_edge_bank_chk
    import irq_edge_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [PIN_W-1:0]   bus_wdata,
    input logic [PIN_W-1:0]   rise_mask,
    input logic [PIN_W-1:0]   fall_mask,
    input logic [PIN_W-1:0]   evt_vec,
    input logic [PIN_W-1:0]   stat_vec,
    input logic [NUM_GRP-1:0] grp_en_q,
    input logic [NUM_GRP-1:0] irq_grp
);
    AST_RISE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_RISE_SET) |=> ((rise_mask & $past(bus_wdata)) == $past(bus_wdata))); // R2
    AST_RISE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_RISE_CLR) |=> ((rise_mask & $past(bus_wdata)) == '0)); // R3
    AST_FALL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_FALL_SET) |=> ((fall_mask & $past(bus_wdata)) == $past(bus_wdata))); // R4
    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vec != '0) |=> ((stat_vec & $past(evt_vec)) == $past(evt_vec))); // R9
    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_STATUS) |=> ((stat_vec & $past(bus_wdata & ~evt_vec)) == '0)); // R8
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_vec & ~$past(stat_vec) & ~$past(evt_vec)) == '0)); // R5
    AST_LO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_en_q[0] |-> !irq_grp[0]); // R10
    AST_HI_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_grp[1] |-> (|stat_vec[PIN_W-1:GRP_W])); // R11
endmodule

bind irq_edge_bank irq_edge_bank_chk chk_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rise_mask(rise_mask), .fall_mask(fall_mask),
    .evt_vec(evt_vec), .stat_vec(stat_vec), .grp_en_q(grp_en_q), .irq_grp(irq_grp)
);

// File: tb/irq_edge_bank_tb_top.sv
module irq_edge_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;
    // vector: pin[31:0], wr, addr[7:0], wdata[31:0], exp_stat[31:0], exp_irq[1:0]
    localparam logic [106:0] VEC [NVEC] = '{
        {32'h0000_0000, 1'b1, 8'h14, 32'h0000_0001, 32'h0000_0000, 2'b00}, // R2 set rise pin0
        {32'h0000_0000, 1'b1, 8'h1C, 32'h0001_0000, 32'h0000_0000, 2'b00}, // R4 set fall pin16
        {32'h0000_0000, 1'b1, 8'h08, 32'h0000_0003, 32'h0000_0000, 2'b00}, // R10
        {32'h0001_0001, 1'b0, 8'h00, 32'h0000_0000, 32'h0000_0001, 2'b01}, // R5 rise, pin16 rise ignored
        {32'h0000_0000, 1'b0, 8'h00, 32'h0000_0000, 32'h0001_0001, 2'b11}, // R6 pin16 fall
        {32'h0000_0000, 1'b1, 8'h24, 32'h0000_0001, 32'h0001_0000, 2'b10}, // R8 clear
        {32'h0000_0000, 1'b1, 8'h24, 32'h0001_0000, 32'h0000_0000, 2'b00}, // R8 R11
        {32'h0000_0000, 1'b1, 8'h1C, 32'h0000_0001, 32'h0000_0000, 2'b00}, // R7 both on pin0
        {32'h0000_0001, 1'b0, 8'h00, 32'h0000_0000, 32'h0000_0001, 2'b01}, // R7 rise
        {32'h0000_0000, 1'b1, 8'h24, 32'h0000_0001, 32'h0000_0001, 2'b01}, // R9 fall with clear
        {32'h0000_0000, 1'b1, 8'h08, 32'h0000_0002, 32'h0000_0001, 2'b00}, // R10 gated
        {32'h0000_0000, 1'b1, 8'h24, 32'hFFFF_FFFF, 32'h0000_0000, 2'b00}, // R8
        {32'h0000_0000, 1'b1, 8'h18, 32'h0000_0001, 32'h0000_0000, 2'b00}, // R3
        {32'h0000_0001, 1'b0, 8'h00, 32'h0000_0000, 32'h0000_0000, 2'b00}, // R3 rise ignored
        {32'h0000_0000, 1'b0, 8'h00, 32'h0000_0000, 32'h0000_0001, 2'b00}, // R6 R10 gated
        {32'h0000_0000, 1'b1, 8'h24, 32'h0000_0000, 32'h0000_0001, 2'b00}, // R8 zeros
        {32'h0000_0000, 1'b1, 8'h08, 32'h0000_0003, 32'h0000_0001, 2'b01}  // R11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_in = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq_grp;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    irq_edge_bank dut_i (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_grp(irq_grp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [31:0] pin, input logic wr, input logic [7:0] a,
                        input logic [31:0] d);
        @(negedge clk);
        pin_in = pin; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1;
        rd(8'h24, v); check("R1 status", v, 0);
        rd(8'h14, v); check("R1 rise", v, 0);
        rd(8'h1C, v); check("R1 fall", v, 0);
        rd(8'h08, v); check("R1 grp", v, 0);
        check("R1 irq", {30'd0, irq_grp}, 0);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][106:75], VEC[i][74], VEC[i][73:66], VEC[i][65:34]);
            rd(8'h24, v);
            check($sformatf("vec%0d status", i), v, VEC[i][33:2]);
            check($sformatf("vec%0d irq", i), {30'd0, irq_grp}, {30'd0, VEC[i][1:0]});
        end

        // R2 read-back from both addresses, zeros leave others alone
        step(32'h0, 1'b1, 8'h14, 32'h8000_0000);
        rd(8'h14, v); check("R2 read set", v, 32'h8000_0000);
        rd(8'h18, v); check("R2 read clr", v, 32'h8000_0000);
        step(32'h0, 1'b1, 8'h14, 32'h0);
        rd(8'h14, v); check("R2 zeros", v, 32'h8000_0000);
        // R4 fall mask readback and clear
        rd(8'h20, v); check("R4 read", v, 32'h0001_0001);
        step(32'h0, 1'b1, 8'h20, 32'h0000_0001);
        rd(8'h1C, v); check("R4 clr", v, 32'h0001_0000);
        // R10 upper bits read zero
        step(32'h0, 1'b1, 8'h08, 32'hFFFF_FFFE);
        rd(8'h08, v); check("R10 read", v, 32'h2);
        // R12 unmapped
        rd(8'h00, v); check("R12 unmapped", v, 0);
        rd(8'h28, v); check("R12 unmapped hi", v, 0);
        // R1 reset mid-run
        @(negedge clk) rst_n = 1'b0;
        #1;
        rd(8'h24, v); check("R1 rst status", v, 0);
        rd(8'h18, v); check("R1 rst rise", v, 0);
        check("R1 rst irq", {30'd0, irq_grp}, 0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule